// File: doc/BRIEF.md
# Latched-Address Static RAM Access Sequencer

This block sits between a clocked host and an asynchronous static memory that captures its address when the chip enable goes low. The host issues one request at a time over a valid/ready handshake: an address, a write flag and write data. The sequencer then drives the memory's address bus, active-low enable, active-low write strobe and the host side of the shared data bus (separate drive value, drive enable and sampled input). When a read finishes, the captured data comes back with a single-cycle valid pulse.

Every analog timing limit of the memory is a parameter in nanoseconds. Each one is converted to a whole number of clock cycles by rounding up against a clock-period parameter. One access always follows the same order: idle, address setup with enable high, enable low (the access or write pulse), enable high precharge, then idle again. The enable-low phase lasts long enough for the enable pulse width, the read access time, the write pulse width and the write data setup. The precharge phase covers the enable-high width, the release time of the memory's output and the total cycle time.

Top module: `lar_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, enable and write strobe are high (inactive), the data drive enable is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: `req_ready` is 1 only in idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1, and `req_ready` is 0 on the next cycle.
- R3: The address changes only when a request is taken. It is stable for at least ceil(T_ADDR_SU_NS/CLK_NS) cycles before enable falls and stays unchanged while enable is low and after it rises.
- R4: Enable stays low for exactly LOW_CYC cycles. LOW_CYC is the largest of the rounded-up enable-low width, read access time, write pulse width and write data setup time (30 cycles at the defaults).
- R5: Between two accesses enable stays high for at least the rounded-up enable-high width (12 cycles at the defaults). Two consecutive falling edges of enable are at least the rounded-up cycle time apart (42 cycles at the defaults).
- R6: On a write the strobe falls on the same edge as enable and rises on the same edge as enable. It is low only while enable is low, for at least the rounded-up write pulse width.
- R7: The host drives the data bus only while the write strobe is low, holds the value unchanged for the whole strobe, and drops the drive when the strobe rises. It never turns the drive on while the memory could still be driving, that is, within the release time after a read's enable rises.
- R8: For a read, the data bus is sampled on the last edge of the enable-low phase. `rsp_valid` is a one-cycle pulse that appears SETUP_CYC+LOW_CYC cycles after the accept edge, on the cycle where enable has just risen.
- R9: A write never produces a `rsp_valid` pulse.
- R10: A request presented while the sequencer is busy has no effect. It does not change the access in progress, and no memory cell is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read data valid pulse |
| rsp_rdata | output | DATA_W | Read data |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_en_n | output | 1 | Memory enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_dq_out | output | DATA_W | Value the host drives onto the data bus |
| mem_dq_oe | output | 1 | Host data drive enable |
| mem_dq_in | input | DATA_W | Value seen on the data bus |

## Verification
With the default parameters, enable falls 2 cycles after the accept edge and rises 30 cycles later. The read pulse is due on the 33rd falling clock edge after the request is dropped, and idle returns 12 cycles after that. The bench samples everything on falling clock edges. A read's latency is counted edge by edge and checked against the value the bench computes from the nanosecond parameters, and the pulse must be gone on the next edge. A memory model in the bench puts the inverted value on the bus until 299 ns after enable falls, so any early sample returns wrong data. A monitor measures the enable widths, the address stability, the strobe width and the data stability as each edge of enable or strobe arrives.

// File: rtl/lar_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the latched-address RAM sequencer.
// Assumes all timing figures are non-negative integers in nanoseconds.
package lar_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_LOW   = 2'd2,
        PH_HIGH  = 2'd3
    } lar_phase_e;

    // Round a nanosecond interval up to whole clock cycles, at least one.
    function automatic int ns2cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/lar_phase_seq.sv
`timescale 1ns/1ps
// Phase sequencer: steps idle -> setup -> enable low -> precharge -> idle.
// Each phase except idle lasts a fixed number of cycles. Assumes every
// count is at least 1; start is honoured only in idle.
module lar_phase_seq
    import lar_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int LOW_CYC   = 30,
    parameter int HIGH_CYC  = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output lar_phase_e phase,
    output logic       phase_end
);
    localparam int MAX_CYC = imax(imax(SETUP_CYC, LOW_CYC), HIGH_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt;

    // Last cycle of the current timed phase.
    assign phase_end = (cnt == '0);

    // Phase register and down counter for the remaining cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (start) begin
                    phase <= PH_SETUP;
                    cnt   <= CNT_W'(SETUP_CYC - 1);
                end
                PH_SETUP: if (phase_end) begin
                    phase <= PH_LOW;
                    cnt   <= CNT_W'(LOW_CYC - 1);
                end else cnt <= cnt - 1'b1;
                PH_LOW: if (phase_end) begin
                    phase <= PH_HIGH;
                    cnt   <= CNT_W'(HIGH_CYC - 1);
                end else cnt <= cnt - 1'b1;
                PH_HIGH: if (phase_end) begin
                    phase <= PH_IDLE;
                end else cnt <= cnt - 1'b1;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R2: leaving idle needs a start, and only idle may take one.
    a_r2_leave_idle_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !start) |=> (phase == PH_IDLE));
endmodule

// File: rtl/lar_bus_drv.sv
`timescale 1ns/1ps
// Memory-side bus driver: holds the accepted request and decodes the
// strobes from the phase register. The address is held from accept to the
// next accept, which covers setup before and hold after enable falls.
module lar_bus_drv
    import lar_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  lar_phase_e        phase,
    output logic              is_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_en_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe
);
    logic in_low;

    // Capture the request fields on accept; hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
            is_write   <= 1'b0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
            is_write   <= req_write;
        end
    end

    // Strobes and drive enable follow the registered phase.
    always_comb begin
        in_low    = (phase == PH_LOW);
        mem_en_n  = !in_low;
        mem_we_n  = !(in_low && is_write);
        mem_dq_oe = in_low && is_write;
    end

    // R3: address only moves on an accepted request.
    a_r3_addr_moves_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(mem_addr));
    // R3: address already settled on the edge where enable falls.
    a_r3_addr_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_en_n) |-> $stable(mem_addr));
    // R6: write strobe never active without enable.
    a_r6_we_inside_en: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_en_n);
    // R6: strobe releases together with enable.
    a_r6_we_rises_with_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> $rose(mem_en_n));
    // R7: driven data does not change during the strobe.
    a_r7_dq_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && !$rose(mem_dq_oe)) |-> $stable(mem_dq_out));
    // R7: drive starts only as a fresh enable-low phase begins.
    a_r7_drive_starts_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> $fell(mem_en_n));
endmodule

// File: rtl/lar_rd_capture.sv
`timescale 1ns/1ps
// Read capture: samples the data bus on the last edge of a read's
// enable-low phase and raises a one-cycle valid pulse. Assumes the
// enable-low phase already covers the memory's access time.
module lar_rd_capture
    import lar_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  lar_phase_e        phase,
    input  logic              phase_end,
    input  logic              is_write,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    logic take;

    // Sample point: final cycle of enable low on a read.
    assign take = (phase == PH_LOW) && phase_end && !is_write;

    // Register the read data and the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= take;
            if (take) rsp_rdata <= mem_dq_in;
        end
    end

    // R8: valid is a single-cycle pulse.
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R8/R9: a pulse follows a read's enable-low phase only.
    a_r9_pulse_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(phase) == PH_LOW && !is_write));
endmodule

// File: rtl/lar_seq.sv
`timescale 1ns/1ps
// Top: latched-address static RAM access sequencer. Converts the memory's
// nanosecond limits into cycle counts (rounded up) and runs one access per
// accepted request. Assumes the data bus tri-state is built outside from
// mem_dq_out / mem_dq_oe, with mem_dq_in reading the bus back.
module lar_seq
    import lar_pkg::*;
#(
    parameter int ADDR_W         = 10,
    parameter int DATA_W         = 4,
    parameter int CLK_NS         = 10,
    parameter int T_ADDR_SU_NS   = 20,
    parameter int T_EN_LOW_NS    = 300,
    parameter int T_EN_HIGH_NS   = 120,
    parameter int T_CYCLE_NS     = 420,
    parameter int T_ACCESS_NS    = 300,
    parameter int T_WR_LOW_NS    = 300,
    parameter int T_WR_DSU_NS    = 200,
    parameter int T_RELEASE_NS   = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_en_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int SETUP_CYC = ns2cyc(T_ADDR_SU_NS, CLK_NS);
    localparam int LOW_CYC   = imax(imax(ns2cyc(T_EN_LOW_NS, CLK_NS), ns2cyc(T_ACCESS_NS, CLK_NS)),
                                    imax(ns2cyc(T_WR_LOW_NS, CLK_NS), ns2cyc(T_WR_DSU_NS, CLK_NS)));
    localparam int HIGH_CYC  = imax(imax(ns2cyc(T_EN_HIGH_NS, CLK_NS), ns2cyc(T_RELEASE_NS, CLK_NS)),
                                    ns2cyc(T_CYCLE_NS, CLK_NS) - LOW_CYC);
    localparam int RUN_W     = $clog2(imax(LOW_CYC, HIGH_CYC) + 2);

    lar_phase_e phase;
    logic       phase_end;
    logic       accept;
    logic       is_write;

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid && req_ready;

    lar_phase_seq #(
        .SETUP_CYC (SETUP_CYC),
        .LOW_CYC   (LOW_CYC),
        .HIGH_CYC  (HIGH_CYC)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .phase     (phase),
        .phase_end (phase_end)
    );

    lar_bus_drv #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .phase      (phase),
        .is_write   (is_write),
        .mem_addr   (mem_addr),
        .mem_en_n   (mem_en_n),
        .mem_we_n   (mem_we_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe)
    );

    lar_rd_capture #(
        .DATA_W (DATA_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .phase_end (phase_end),
        .is_write  (is_write),
        .mem_dq_in (mem_dq_in),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    // Checker state: run lengths of enable low and high, measured at the pins.
    logic [RUN_W-1:0] low_run;
    logic [RUN_W-1:0] high_run;
    logic             seen_rise;

    // Count consecutive cycles of each enable level (high count saturates).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run   <= '0;
            high_run  <= '0;
            seen_rise <= 1'b0;
        end else begin
            low_run  <= mem_en_n ? '0 : low_run + 1'b1;
            if (!mem_en_n)                      high_run <= '0;
            else if (high_run != RUN_W'(HIGH_CYC)) high_run <= high_run + 1'b1;
            if ($rose(mem_en_n)) seen_rise <= 1'b1;
        end
    end

    // R1: idle outputs on the first cycle after reset.
    a_r1_reset_state: assert property (@(posedge clk)
        !$past(rst_n) |-> (mem_en_n && mem_we_n && !mem_dq_oe && !rsp_valid && req_ready));
    // R2: a taken request makes the sequencer busy.
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R4: enable-low phase has the exact length.
    a_r4_low_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_en_n) |-> (low_run == RUN_W'(LOW_CYC)));
    // R5: precharge long enough before the next falling edge.
    a_r5_high_width: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_en_n) && seen_rise) |-> (high_run == RUN_W'(HIGH_CYC)));
    // R10: no request is taken while an access is running.
    a_r10_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |-> !accept);
endmodule

// File: tb/lar_seq_tb.sv
`timescale 1ns/1ps
// Bench for lar_seq: a behavioural latched-address memory, a pin monitor,
// directed corner cases and seeded random traffic checked against a model.
module lar_seq_tb;
    localparam int AW = 10;
    localparam int DW = 4;
    localparam int CLKNS = 10;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + CLKNS - 1) / CLKNS;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_SETUP = cyc(20);
    localparam int E_LOW   = mx(mx(cyc(300), cyc(300)), mx(cyc(300), cyc(200)));
    localparam int E_HIGHMIN = cyc(120);
    localparam int E_CYC   = cyc(420);
    localparam int E_WLOW  = cyc(300);
    localparam int E_DSU   = cyc(200);
    localparam int E_RDLAT = E_SETUP + E_LOW + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, mem_en_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
    logic [AW-1:0] mem_addr;

    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    lar_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_en_n(mem_en_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Memory model: address latched at enable fall, wrong data before 299 ns.
    logic [DW-1:0] mem [1024];
    logic [DW-1:0] ref_mem [1024];
    logic [AW-1:0] lat_addr = '0;
    logic rd_ok = 1'b0, rel_win = 1'b0, cur_rd = 1'b0;

    always @(negedge mem_en_n) begin
        rd_ok = 1'b0;
        lat_addr = mem_addr;
        #299;
        rd_ok = 1'b1;
    end
    always @(posedge mem_en_n) begin
        if (cur_rd) begin
            rel_win = 1'b1;
            #99;
            rel_win = 1'b0;
        end
    end
    assign mem_dq_in = (!mem_en_n && mem_we_n) ?
                       (rd_ok ? mem[lat_addr] : ~mem[lat_addr]) : '0;

    // Pin monitor on falling clock edges.
    logic prev_en = 1'b1, prev_we = 1'b1, prev_oe = 1'b0, seen_fall = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    logic [DW-1:0] prev_dout = '0, wdat = '0;
    int addr_st = 0, low_cnt = 0, high_cnt = 0, f2f = 0, wlow = 0, dst = 0, moved = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_addr != prev_addr) addr_st = 0; else addr_st++;
            if (!mem_en_n && !prev_en && mem_addr != prev_addr) moved++;
            if (prev_en && !mem_en_n) begin
                chk(addr_st >= E_SETUP, "R3 addr setup cycles", addr_st, E_SETUP);
                if (seen_fall) begin
                    chk(high_cnt >= E_HIGHMIN, "R5 enable high cycles", high_cnt, E_HIGHMIN);
                    chk(f2f >= E_CYC, "R5 fall-to-fall cycles", f2f, E_CYC);
                end
                seen_fall = 1'b1; f2f = 1; low_cnt = 1; moved = 0;
            end else begin
                f2f++;
                if (!mem_en_n) low_cnt++; else high_cnt++;
            end
            if (!prev_en && mem_en_n) begin
                chk(low_cnt == E_LOW, "R4 enable low cycles", low_cnt, E_LOW);
                chk(moved == 0, "R3 addr held while enable low", moved, 0);
                high_cnt = 1;
            end
            if (prev_we && !mem_we_n) begin
                chk(prev_en && !mem_en_n, "R6 strobe falls with enable", mem_en_n, 0);
                wlow = 1; dst = 1;
            end else if (!mem_we_n) begin
                wlow++;
                if (mem_dq_oe && mem_dq_out == prev_dout) dst++; else dst = 0;
            end
            if (!mem_we_n && mem_dq_oe) wdat = mem_dq_out;
            if (!prev_we && mem_we_n) begin
                chk(mem_en_n, "R6 strobe rises with enable", mem_en_n, 1);
                chk(wlow >= E_WLOW, "R6 strobe low cycles", wlow, E_WLOW);
                chk(dst >= E_DSU, "R7 data stable under strobe", dst, E_DSU);
                chk(!mem_dq_oe, "R7 drive released with strobe", mem_dq_oe, 0);
                mem[lat_addr] = wdat;
            end
            if (mem_dq_oe && !prev_oe)
                chk(!rel_win && mem_en_n == 1'b0 && !mem_we_n, "R7 no drive during memory release",
                    rel_win, 0);
            prev_en = mem_en_n; prev_we = mem_we_n; prev_oe = mem_dq_oe;
            prev_addr = mem_addr; prev_dout = mem_dq_out;
        end
    end

    // One access; optionally pokes a stray write while busy (R10).
    task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit poke);
        int n;
        bit got;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        cur_rd = !wr;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R2 busy after accept", req_ready, 0);
        n = 1;
        if (wr) ref_mem[a] = d;
        if (poke) begin
            for (int i = 0; i < 10; i++) begin
                req_valid = 1'b1; req_write = 1'b1;
                req_addr = a ^ 10'h001; req_wdata = ~d;
                @(negedge clk); n++;
                chk(!req_ready, "R10 busy request not taken", req_ready, 0);
            end
            req_valid = 1'b0;
        end
        got = 1'b0;
        while (!req_ready && n < 400) begin
            if (rsp_valid) begin
                if (wr) chk(1'b0, "R9 no pulse on write", 1, 0);
                else begin
                    chk(n == E_RDLAT, "R8 read latency", n, E_RDLAT);
                    chk(rsp_rdata == ref_mem[a], "R8 read data", rsp_rdata, ref_mem[a]);
                    got = 1'b1;
                    @(negedge clk); n++;
                    chk(!rsp_valid, "R8 single-cycle pulse", rsp_valid, 0);
                end
            end
            if (!got || wr) begin @(negedge clk); n++; end
            else got = got;
            if (got && !wr && !rsp_valid) begin
                while (!req_ready && n < 400) begin @(negedge clk); n++; end
            end
        end
        if (!wr) chk(got, "R8 read pulse seen", got, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin mem[i] = '0; ref_mem[i] = '0; end
        void'($urandom(32'h1a2b3c4d));
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(mem_en_n && mem_we_n && !mem_dq_oe && !rsp_valid, "R1 outputs during reset",
            {mem_en_n, mem_we_n, mem_dq_oe, rsp_valid}, 4'b1100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && mem_en_n && mem_we_n && !mem_dq_oe && !rsp_valid, "R1 state after reset",
            {req_ready, mem_en_n, mem_we_n, mem_dq_oe, rsp_valid}, 5'b11100);
        // Directed: address extremes, read back, back-to-back reads.
        access(1'b1, 10'h3FF, 4'hA, 1'b0);
        access(1'b1, 10'h000, 4'h5, 1'b0);
        access(1'b0, 10'h3FF, '0, 1'b0);
        access(1'b0, 10'h000, '0, 1'b0);
        access(1'b0, 10'h000, '0, 1'b0);
        // Read followed at once by write: release window on the bus.
        access(1'b1, 10'h001, 4'hF, 1'b0);
        // Stray request during a busy write must leave 0x006 untouched.
        access(1'b1, 10'h007, 4'h9, 1'b1);
        access(1'b0, 10'h006, '0, 1'b0);
        access(1'b0, 10'h007, '0, 1'b0);
        // Seeded random traffic on a small window to force reuse.
        for (int k = 0; k < 120; k++) begin
            logic [AW-1:0] ra;
            ra = AW'($urandom_range(0, 31));
            access(1'($urandom_range(0, 1)), ra, DW'($urandom), 1'b0);
        end
        repeat (5) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule